// File: doc/BRIEF.md
# Bridge Forwarding Decoder with Legacy Display Ranges

This block sits at the address phase of a two-sided bus bridge. Each request names its arrival side (primary, facing the host, or secondary, facing the devices), an address space (memory or I/O) and an address. One clock later the block states whether the bridge claims the request and sends it to the other side, and whether that claim is positive or subtractive.

Two configurable base/limit windows, one per space, give the normal decode. Primary-side hits go downstream and secondary-side misses go upstream. The legacy display ranges are decoded apart from these windows under a single enable. They are forwarded downstream only and are always held back in the upstream direction. A chain input carries the result of the enclosing bridges' windows, so a downstream claim needs every level to agree. A subtractive mode lets the bridge take primary-side requests that nobody else claimed, which is what a legacy expansion bus behind the bridge needs.

Top module: `bridge_fwd_decoder`

## Requirements
- R1: While rst_ni is low, fwd_valid_o, fwd_o and claim_o are 0. The reset is asynchronous: outputs clear at once, without waiting for a clock edge.
- R2: The decision for a request sampled at a rising edge with req_valid_i high appears on the outputs after that edge, with fwd_valid_o = 1. A cycle with req_valid_i low yields fwd_valid_o = 0 and claim_o = 00.
- R3: claim_o encodes 00 = no claim, 01 = positive, 10 = subtractive. 11 never appears, and fwd_o is 1 exactly when claim_o is not 00.
- R4: With the display enable vga_en_i set, a memory request (req_space_i = 0) is a display hit when its full address lies in 0x000A_0000..0x000B_FFFF inclusive. 0x000C_0000 and above are not display hits, and nothing is a display hit while the enable is clear.
- R5: With vga_en_i set, an I/O request (req_space_i = 1) is a display hit when address bits [31:16] are zero and bits [9:0] lie in 0x3B0..0x3BB or 0x3C0..0x3DF. Bits [15:10] are ignored.
- R6: A primary-side request (req_side_i = 0) that is a display hit is claimed positive when chain_ok_i is 1, whatever the windows hold.
- R7: A secondary-side request (req_side_i = 1) that is a display hit is never forwarded (claim_o = 00), whatever the windows or subtractive mode hold.
- R8: A window of its space is active when base <= limit. A primary-side request inside an active window (base <= addr <= limit) is claimed positive. A secondary-side request that is not a display hit and lies outside the window, or finds it inactive, is claimed positive.
- R9: chain_ok_i = 0 blocks every positive claim of a primary-side request. It has no effect on secondary-side requests.
- R10: With subtr_en_i = 1, a primary-side request without a positive claim and with other_claim_i = 0 is claimed subtractive. A secondary-side request is never claimed subtractive.
- R11: A positive claim takes priority over a subtractive one: a request that qualifies for both gets claim_o = 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_side_i | input | 1 | Arrival side: 0 primary, 1 secondary |
| req_space_i | input | 1 | Address space: 0 memory, 1 I/O |
| req_addr_i | input | ADDR_W | Request address |
| vga_en_i | input | 1 | Enables legacy display range decode |
| mem_base_i | input | ADDR_W | Memory window base |
| mem_limit_i | input | ADDR_W | Memory window limit (inclusive) |
| io_base_i | input | ADDR_W | I/O window base |
| io_limit_i | input | ADDR_W | I/O window limit (inclusive) |
| chain_ok_i | input | 1 | Enclosing bridges all decode this address |
| subtr_en_i | input | 1 | Subtractive decode enable |
| other_claim_i | input | 1 | Another agent positively claimed the request |
| fwd_valid_o | output | 1 | A decision is on the outputs |
| fwd_o | output | 1 | Request is forwarded to the other side |
| claim_o | output | 2 | Claim type (see R3) |

## Verification
Every decision is due exactly one rising edge after its request is sampled. The bench drives a new request at each falling edge and compares all three outputs at the next falling edge, so each check lands half a cycle after the register that produced it. Reset is the only effect checked without a clock edge: it is sampled one time step after rst_ni falls. Expected claims come from an arithmetic model of the ranges and windows, swept over boundary addresses, both sides, both spaces and every control combination.

// File: rtl/bfd_pkg.sv
package bfd_pkg;
  typedef enum logic [1:0] {
    CLAIM_NONE = 2'b00,
    CLAIM_POS  = 2'b01,
    CLAIM_SUB  = 2'b10
  } claim_e;

  localparam logic SIDE_PRI = 1'b0;
  localparam logic SIDE_SEC = 1'b1;
  localparam logic SPACE_MEM = 1'b0;
  localparam logic SPACE_IO  = 1'b1;

  localparam int unsigned DISP_MEM_LO = 32'h000A_0000;
  localparam int unsigned DISP_MEM_HI = 32'h000B_FFFF;
  localparam int unsigned DISP_IO_A_LO = 32'h3B0;
  localparam int unsigned DISP_IO_A_HI = 32'h3BB;
  localparam int unsigned DISP_IO_B_LO = 32'h3C0;
  localparam int unsigned DISP_IO_B_HI = 32'h3DF;
endpackage

// File: rtl/bfd_disp_match.sv
module bfd_disp_match
  import bfd_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned IO_ALIAS_W = 10,
  parameter int unsigned IO_SPACE_W = 16
) (
  input  logic              en_i,
  input  logic              is_io_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam logic [ADDR_W-1:0]     MemLo = ADDR_W'(DISP_MEM_LO);
  localparam logic [ADDR_W-1:0]     MemHi = ADDR_W'(DISP_MEM_HI);
  localparam logic [IO_ALIAS_W-1:0] IoALo = IO_ALIAS_W'(DISP_IO_A_LO);
  localparam logic [IO_ALIAS_W-1:0] IoAHi = IO_ALIAS_W'(DISP_IO_A_HI);
  localparam logic [IO_ALIAS_W-1:0] IoBLo = IO_ALIAS_W'(DISP_IO_B_LO);
  localparam logic [IO_ALIAS_W-1:0] IoBHi = IO_ALIAS_W'(DISP_IO_B_HI);

  logic [IO_ALIAS_W-1:0] io_low;
  logic                  io_top_clear;
  logic                  mem_hit;
  logic                  io_hit;

  assign io_low       = addr_i[IO_ALIAS_W-1:0];
  // alias bits between IO_ALIAS_W and IO_SPACE_W are don't-care
  assign io_top_clear = (addr_i[ADDR_W-1:IO_SPACE_W] == '0);

  assign mem_hit = (addr_i >= MemLo) && (addr_i <= MemHi);
  assign io_hit  = io_top_clear &&
                   (((io_low >= IoALo) && (io_low <= IoAHi)) ||
                    ((io_low >= IoBLo) && (io_low <= IoBHi)));

  assign hit_o = en_i && (is_io_i ? io_hit : mem_hit);
endmodule

// File: rtl/bfd_window.sv
module bfd_window #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] limit_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              active_o,
  output logic              inside_o
);
  assign active_o = (base_i <= limit_i);
  assign inside_o = active_o && (addr_i >= base_i) && (addr_i <= limit_i);
endmodule

// File: rtl/bfd_claim_sel.sv
module bfd_claim_sel
  import bfd_pkg::*;
(
  input  logic   side_i,
  input  logic   disp_hit_i,
  input  logic   win_inside_i,
  input  logic   chain_ok_i,
  input  logic   subtr_en_i,
  input  logic   other_claim_i,
  output claim_e claim_o
);
  logic pri;
  logic pos;
  logic sub;

  assign pri = (side_i == SIDE_PRI);

  always_comb begin
    if (pri) pos = (disp_hit_i || win_inside_i) && chain_ok_i;
    else     pos = !disp_hit_i && !win_inside_i;  // upstream: display ranges held back
  end

  assign sub = pri && subtr_en_i && !other_claim_i;

  always_comb begin
    if (pos)      claim_o = CLAIM_POS;
    else if (sub) claim_o = CLAIM_SUB;
    else          claim_o = CLAIM_NONE;
  end
endmodule

// File: rtl/bridge_fwd_decoder.sv
module bridge_fwd_decoder
  import bfd_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned IO_ALIAS_W = 10,
  parameter int unsigned IO_SPACE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_side_i,
  input  logic              req_space_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              vga_en_i,
  input  logic [ADDR_W-1:0] mem_base_i,
  input  logic [ADDR_W-1:0] mem_limit_i,
  input  logic [ADDR_W-1:0] io_base_i,
  input  logic [ADDR_W-1:0] io_limit_i,
  input  logic              chain_ok_i,
  input  logic              subtr_en_i,
  input  logic              other_claim_i,
  output logic              fwd_valid_o,
  output logic              fwd_o,
  output logic [1:0]        claim_o
);
  localparam int unsigned NumSpaces = 2;

  logic [NumSpaces-1:0][ADDR_W-1:0] win_base;
  logic [NumSpaces-1:0][ADDR_W-1:0] win_limit;
  logic [NumSpaces-1:0]             win_active;
  logic [NumSpaces-1:0]             win_inside;

  assign win_base[SPACE_MEM]  = mem_base_i;
  assign win_limit[SPACE_MEM] = mem_limit_i;
  assign win_base[SPACE_IO]   = io_base_i;
  assign win_limit[SPACE_IO]  = io_limit_i;

  for (genvar s = 0; s < NumSpaces; s++) begin : g_win
    bfd_window #(.ADDR_W(ADDR_W)) u_win (
      .base_i  (win_base[s]),
      .limit_i (win_limit[s]),
      .addr_i  (req_addr_i),
      .active_o(win_active[s]),
      .inside_o(win_inside[s])
    );
  end

  logic disp_hit;

  bfd_disp_match #(
    .ADDR_W    (ADDR_W),
    .IO_ALIAS_W(IO_ALIAS_W),
    .IO_SPACE_W(IO_SPACE_W)
  ) u_disp (
    .en_i   (vga_en_i),
    .is_io_i(req_space_i),
    .addr_i (req_addr_i),
    .hit_o  (disp_hit)
  );

  claim_e claim_d;

  bfd_claim_sel u_sel (
    .side_i       (req_side_i),
    .disp_hit_i   (disp_hit),
    .win_inside_i (win_inside[req_space_i]),
    .chain_ok_i   (chain_ok_i),
    .subtr_en_i   (subtr_en_i),
    .other_claim_i(other_claim_i),
    .claim_o      (claim_d)
  );

  logic   valid_q;
  logic   fwd_q;
  claim_e claim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      fwd_q   <= 1'b0;
      claim_q <= CLAIM_NONE;
    end else begin
      valid_q <= req_valid_i;
      fwd_q   <= req_valid_i && (claim_d != CLAIM_NONE);
      claim_q <= req_valid_i ? claim_d : CLAIM_NONE;
    end
  end

  assign fwd_valid_o = valid_q;
  assign fwd_o       = fwd_q;
  assign claim_o     = claim_q;

  logic unused_active;
  assign unused_active = ^win_active;
endmodule

// File: rtl/bfd_checker.sv
module bfd_checker #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_side_i,
  input logic              req_space_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              vga_en_i,
  input logic              chain_ok_i,
  input logic              fwd_valid_o,
  input logic              fwd_o,
  input logic [1:0]        claim_o
);
  logic disp_mem;
  assign disp_mem = vga_en_i && !req_space_i &&
                    (req_addr_i >= ADDR_W'(32'h000A_0000)) &&
                    (req_addr_i <= ADDR_W'(32'h000B_FFFF));

  a_r2_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!fwd_valid_o && claim_o == 2'b00));
  a_r2_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> fwd_valid_o);
  a_r3_encoding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_o != 2'b11);
  a_r3_fwd_matches_claim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_o == (claim_o != 2'b00));
  a_r7_upstream_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_side_i && disp_mem) |=> !fwd_o);
  a_r6_downstream_claim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_side_i && chain_ok_i && disp_mem) |=> claim_o == 2'b01);
  a_r9_chain_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_side_i && !chain_ok_i) |=> claim_o != 2'b01);
  a_r10_no_sub_upstream: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_side_i) |=> claim_o != 2'b10);
endmodule

bind bridge_fwd_decoder bfd_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_side_i (req_side_i),
  .req_space_i(req_space_i),
  .req_addr_i (req_addr_i),
  .vga_en_i   (vga_en_i),
  .chain_ok_i (chain_ok_i),
  .fwd_valid_o(fwd_valid_o),
  .fwd_o      (fwd_o),
  .claim_o    (claim_o)
);

// File: tb/bridge_fwd_decoder_tb.sv
module bridge_fwd_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic              req_side_i = 1'b0;
  logic              req_space_i = 1'b0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic              vga_en_i = 1'b0;
  logic [ADDR_W-1:0] mem_base_i = '0;
  logic [ADDR_W-1:0] mem_limit_i = '0;
  logic [ADDR_W-1:0] io_base_i = '0;
  logic [ADDR_W-1:0] io_limit_i = '0;
  logic              chain_ok_i = 1'b1;
  logic              subtr_en_i = 1'b0;
  logic              other_claim_i = 1'b0;
  logic              fwd_valid_o;
  logic              fwd_o;
  logic [1:0]        claim_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bridge_fwd_decoder u_dut (.*);

  // Spec model: display ranges, windows, side, chain, subtractive.
  function automatic logic [1:0] model(input logic side, input logic io,
                                       input logic [31:0] a);
    logic disp, inwin, pos;
    logic [31:0] b, l;
    int lo;
    lo = int'(a % 1024);
    if (io) disp = vga_en_i && (a < 32'h1_0000) &&
                   ((lo >= 944 && lo <= 955) || (lo >= 960 && lo <= 991));
    else    disp = vga_en_i && (a >= 32'd655360) && (a <= 32'd786431);
    b = io ? io_base_i : mem_base_i;
    l = io ? io_limit_i : mem_limit_i;
    inwin = (b <= l) && (a >= b) && (a <= l);
    if (side == 1'b0) pos = (disp || inwin) && chain_ok_i;
    else              pos = !disp && !inwin;
    if (pos) return 2'b01;
    if (side == 1'b0 && subtr_en_i && !other_claim_i) return 2'b10;
    return 2'b00;
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {valid,fwd,claim} actual=%b expected=%b addr=%h side=%b io=%b",
               tag, act, exp, req_addr_i, req_side_i, req_space_i);
    end
  endtask

  // Drive at a falling edge, check at the next falling edge.
  task automatic run_req(input string tag, input logic side, input logic io,
                         input logic [31:0] a);
    logic [1:0] e;
    req_valid_i = 1'b1;
    req_side_i  = side;
    req_space_i = io;
    req_addr_i  = a;
    e = model(side, io, a);
    @(negedge clk_i);
    check(tag, {fwd_valid_o, fwd_o, claim_o}, {1'b1, e != 2'b00, e});
    n_tests++;
    if (fwd_o !== (claim_o != 2'b00) || claim_o === 2'b11) begin
      n_fail++;
      $display("FAIL R3: fwd=%b claim=%b", fwd_o, claim_o);
    end
  endtask

  function automatic string tag_for(input logic side, input logic [1:0] e);
    if (e == 2'b10) return "R10";
    if (!chain_ok_i && side == 1'b0) return "R9";
    if (vga_en_i && side == 1'b1) return "R7";
    if (vga_en_i && side == 1'b0 && subtr_en_i) return "R11";
    if (vga_en_i) return "R6";
    return "R8";
  endfunction

  initial begin
    logic [31:0] addrs[20];
    // R1: outputs held clear while reset asserted, even with a request
    req_valid_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R1", {fwd_valid_o, fwd_o, claim_o}, 4'b0000);
    req_valid_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R2: idle cycle
    check("R2", {fwd_valid_o, fwd_o, claim_o}, 4'b0000);

    // Main sweep over window configurations and all controls (R6..R11)
    for (int cfg = 0; cfg < 3; cfg++) begin
      case (cfg)
        0: begin mem_base_i = 32'h1000_0000; mem_limit_i = 32'h1FFF_FFFF;
                 io_base_i = 32'h1000; io_limit_i = 32'h1FFF; end
        1: begin mem_base_i = 32'h2000_0000; mem_limit_i = 32'h1000_0000;
                 io_base_i = 32'h3000; io_limit_i = 32'h2000; end
        default: begin mem_base_i = 32'h0; mem_limit_i = 32'h000F_FFFF;
                 io_base_i = 32'h0; io_limit_i = 32'h0FFF; end
      endcase
      for (int sp = 0; sp < 2; sp++) begin
        logic [31:0] b, l;
        b = sp ? io_base_i : mem_base_i;
        l = sp ? io_limit_i : mem_limit_i;
        addrs = '{b - 1, b, b + 1, l - 1, l, l + 1,
                  32'h9FFFF, 32'hA0000, 32'hBFFFF, 32'hC0000,
                  32'h3AF, 32'h3B0, 32'h3BB, 32'h3BC, 32'h3BF,
                  32'h3C0, 32'h3DF, 32'h3E0, 32'h7BB, 32'h1_03C0};
        for (int ctl = 0; ctl < 32; ctl++) begin
          vga_en_i      = ctl[0];
          subtr_en_i    = ctl[1];
          other_claim_i = ctl[2];
          chain_ok_i    = ctl[3];
          for (int k = 0; k < 20; k++) begin
            logic side;
            side = ctl[4];
            run_req(tag_for(side, model(side, sp[0], addrs[k])), side, sp[0], addrs[k]);
          end
        end
      end
    end

    // R5: every low I/O address with scattered alias bits, windows inactive
    mem_base_i = 32'h10; mem_limit_i = 32'h0;
    io_base_i = 32'h10; io_limit_i = 32'h0;
    vga_en_i = 1'b1; chain_ok_i = 1'b1; subtr_en_i = 1'b0; other_claim_i = 1'b0;
    for (int lo = 0; lo < 1024; lo++) begin
      logic [31:0] a;
      a = (32'((lo * 37) % 64) << 10) | 32'(lo);
      run_req("R5", 1'b0, 1'b1, a);
    end
    run_req("R5", 1'b0, 1'b1, 32'h0001_03B0);
    run_req("R5", 1'b0, 1'b1, 32'h8000_FFC0);

    // R4: memory scan across the display range and the area above it
    for (int a = 32'h9_FF00; a <= 32'hC_0100; a += 32'h80) begin
      run_req("R4", 1'b0, 1'b0, 32'(a));
    end
    vga_en_i = 1'b0;
    run_req("R4", 1'b0, 1'b0, 32'hA_0000);
    run_req("R4", 1'b0, 1'b0, 32'hB_FFFF);

    // R2: request followed by idle returns to no claim
    vga_en_i = 1'b1;
    run_req("R2", 1'b0, 1'b0, 32'hA_1234);
    req_valid_i = 1'b0;
    @(negedge clk_i);
    check("R2", {fwd_valid_o, fwd_o, claim_o}, 4'b0000);

    // R1: asynchronous clear mid-cycle after a positive claim
    run_req("R1", 1'b0, 1'b0, 32'hA_0000);
    #(CLK_PERIOD/4);
    rst_ni = 1'b0;
    #1;
    check("R1", {fwd_valid_o, fwd_o, claim_o}, 4'b0000);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule